// File: doc/BRIEF.md
# Two-Port Semaphore Bank

This block holds eight one-bit semaphores that two independent ports share. Each port has its own select strobe, a 3-bit semaphore index, a write strobe, a write value and a registered read result. A semaphore works as a token. Only one side can own a given semaphore at a time, and owning it tells the other side that the resource the semaphore stands for is in use. Software on either side takes a token by writing 0 and gives it back by writing 1. It reads the index to learn whether it now owns the token.

A request for a token that the other side holds is not lost. It stays queued inside that semaphore, and the token passes to the waiting side on the same clock edge that the holder's release takes effect. When both sides ask for a free token in the same cycle, the left port wins and the right port's request waits. Each write is checked against the ownership held at the start of its cycle. A read reports that same start-of-cycle state one clock later. The read result keeps its value until the port's next read.

Top module: `sem_bank`

## Requirements
- R1: After reset all eight semaphores are free, no request is waiting, and both read outputs are 1. A read of any index 0 to 7 from either port then returns 1.
- R2: No semaphore is ever owned by the left and right ports at the same time.
- R3: A cycle with select=1, write=1 and value=0 is a request. A request for a free semaphore makes the requesting port its owner at the next clock edge.
- R4: A cycle with select=1 and write=0 is a read. At the next edge the read output becomes 0 if the reading port owned the indexed semaphore at the start of the read cycle, and 1 otherwise. This includes the case where that port only has a request waiting.
- R5: A cycle with select=1, write=1 and value=1 is a release. A release by the owner with no request waiting from the other side leaves the semaphore free.
- R6: A request for a semaphore owned by the other port leaves the owner unchanged and keeps the request waiting. A waiting request exists only while the other port owns that semaphore.
- R7: When the owner releases a semaphore that the other port is waiting for, the waiting port becomes the owner at that same edge and its waiting state clears.
- R8: When both ports request the same free semaphore in one cycle, the left port becomes owner and the right port's request waits.
- R9: A release written by a port that does not own the semaphore changes neither its owner nor any waiting request.
- R10: While select is 0, the write, value and index inputs of that port have no effect. The read output changes only after a read cycle.
- R11: A request by the port that already owns the semaphore, or a repeated waiting request, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port semaphore select strobe |
| l_wr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_idx | input | 3 | Left port semaphore index |
| l_wdata | input | 1 | Left port write value (0 = request, 1 = release) |
| l_rdata | output | 1 | Left port read result (0 = owned by left) |
| r_sel | input | 1 | Right port semaphore select strobe |
| r_wr | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_idx | input | 3 | Right port semaphore index |
| r_wdata | input | 1 | Right port write value (0 = request, 1 = release) |
| r_rdata | output | 1 | Right port read result (0 = owned by right) |

## Verification
The assertions check on every cycle the properties that hold in every state:
- exclusive ownership;
- a waiting request only while the other side owns the semaphore;
- ownership kept until its owner releases;
- handoff on release;
- left priority on a tie;
- releases from a non-owner doing nothing;
- read results that follow the start-of-cycle ownership and otherwise hold.

Only the bench's scenarios can show that the reset state is visible through reads on all eight indices and that a held token can be queued for, handed off and freed in sequence. A long mixed run compared cycle by cycle against a behavioural model covers interleavings of reads and writes on both ports.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   wait_l;
        logic   wait_r;
    } sem_cell_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_READ = 2'd1,
        OP_TAKE = 2'd2,
        OP_GIVE = 2'd3
    } port_op_e;

    typedef struct packed {
        logic rdata;
    } rd_state_t;

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec
    import sem_pkg::*;
#(
    parameter int N_SEM = 8,
    parameter int IDX_W = 3
) (
    input  logic             sel,
    input  logic             wr,
    input  logic             wdata,
    input  logic [IDX_W-1:0] idx,
    output logic [N_SEM-1:0] take_vec,
    output logic [N_SEM-1:0] give_vec,
    output logic             rd_en
);

    port_op_e op;

    always_comb begin
        op = OP_IDLE;
        if (sel) begin
            if (!wr) begin
                op = OP_READ;
            end else if (wdata) begin
                op = OP_GIVE;
            end else begin
                op = OP_TAKE;
            end
        end
    end

    always_comb begin
        take_vec = '0;
        give_vec = '0;
        for (int k = 0; k < N_SEM; k++) begin
            if (idx == IDX_W'(k)) begin
                take_vec[k] = (op == OP_TAKE);
                give_vec[k] = (op == OP_GIVE);
            end
        end
        rd_en = (op == OP_READ);
    end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_l,
    input  logic give_l,
    input  logic take_r,
    input  logic give_r,
    output logic held_l,
    output logic held_r,
    output logic wait_l,
    output logic wait_r
);

    sem_cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // releases are judged against the start-of-cycle owner
        if (give_l && st_q.owner == OWN_LEFT) begin
            if (st_q.wait_r) begin
                st_d.owner  = OWN_RIGHT;
                st_d.wait_r = 1'b0;
            end else begin
                st_d.owner = OWN_NONE;
            end
        end
        if (give_r && st_q.owner == OWN_RIGHT) begin
            if (st_q.wait_l) begin
                st_d.owner  = OWN_LEFT;
                st_d.wait_l = 1'b0;
            end else begin
                st_d.owner = OWN_NONE;
            end
        end

        // requests see the post-release owner; left is applied first
        if (take_l) begin
            case (st_d.owner)
                OWN_NONE:  st_d.owner  = OWN_LEFT;
                OWN_RIGHT: st_d.wait_l = 1'b1;
                default:   ;
            endcase
        end
        if (take_r) begin
            case (st_d.owner)
                OWN_NONE:  st_d.owner  = OWN_RIGHT;
                OWN_LEFT:  st_d.wait_r = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign held_l = (st_q.owner == OWN_LEFT);
    assign held_r = (st_q.owner == OWN_RIGHT);
    assign wait_l = st_q.wait_l;
    assign wait_r = st_q.wait_r;

endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port
    import sem_pkg::*;
#(
    parameter int N_SEM = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [N_SEM-1:0] held,
    output logic             rdata
);

    rd_state_t rd_d, rd_q;
    logic      mine;

    always_comb begin
        mine = 1'b0;
        for (int k = 0; k < N_SEM; k++) begin
            if (idx == IDX_W'(k)) begin
                mine = held[k];
            end
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.rdata = ~mine;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '{rdata: 1'b1};
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.rdata;

endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int N_SEM = 8,
    localparam int IDX_W = (N_SEM > 1) ? $clog2(N_SEM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_sel,
    input  logic             l_wr,
    input  logic [IDX_W-1:0] l_idx,
    input  logic             l_wdata,
    output logic             l_rdata,
    input  logic             r_sel,
    input  logic             r_wr,
    input  logic [IDX_W-1:0] r_idx,
    input  logic             r_wdata,
    output logic             r_rdata
);

    logic [N_SEM-1:0] take_l_w, give_l_w, take_r_w, give_r_w;
    logic [N_SEM-1:0] held_l_w, held_r_w, wait_l_w, wait_r_w;
    logic             rd_l_w, rd_r_w;

    sem_port_dec #(.N_SEM(N_SEM), .IDX_W(IDX_W)) u_dec_l (
        .sel      (l_sel),
        .wr       (l_wr),
        .wdata    (l_wdata),
        .idx      (l_idx),
        .take_vec (take_l_w),
        .give_vec (give_l_w),
        .rd_en    (rd_l_w)
    );

    sem_port_dec #(.N_SEM(N_SEM), .IDX_W(IDX_W)) u_dec_r (
        .sel      (r_sel),
        .wr       (r_wr),
        .wdata    (r_wdata),
        .idx      (r_idx),
        .take_vec (take_r_w),
        .give_vec (give_r_w),
        .rd_en    (rd_r_w)
    );

    for (genvar g = 0; g < N_SEM; g++) begin : g_cell
        sem_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .take_l (take_l_w[g]),
            .give_l (give_l_w[g]),
            .take_r (take_r_w[g]),
            .give_r (give_r_w[g]),
            .held_l (held_l_w[g]),
            .held_r (held_r_w[g]),
            .wait_l (wait_l_w[g]),
            .wait_r (wait_r_w[g])
        );
    end

    sem_rd_port #(.N_SEM(N_SEM), .IDX_W(IDX_W)) u_rd_l (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_l_w),
        .idx   (l_idx),
        .held  (held_l_w),
        .rdata (l_rdata)
    );

    sem_rd_port #(.N_SEM(N_SEM), .IDX_W(IDX_W)) u_rd_r (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_r_w),
        .idx   (r_idx),
        .held  (held_r_w),
        .rdata (r_rdata)
    );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int N_SEM = 8,
    localparam int IDX_W = (N_SEM > 1) ? $clog2(N_SEM) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             l_sel,
    input logic             l_wr,
    input logic [IDX_W-1:0] l_idx,
    input logic             l_wdata,
    input logic             l_rdata,
    input logic             r_sel,
    input logic             r_wr,
    input logic [IDX_W-1:0] r_idx,
    input logic             r_wdata,
    input logic             r_rdata,
    input logic [N_SEM-1:0] held_l,
    input logic [N_SEM-1:0] held_r,
    input logic [N_SEM-1:0] wait_l,
    input logic [N_SEM-1:0] wait_r
);

    logic l_rd, r_rd;
    assign l_rd = l_sel && !l_wr;
    assign r_rd = r_sel && !r_wr;

    AST_READ_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd |=> (l_rdata == !$past(held_l[l_idx])));  // R4
    AST_READ_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        r_rd |=> (r_rdata == !$past(held_r[r_idx])));  // R4
    AST_RDATA_HOLD_L: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd |=> $stable(l_rdata));  // R10
    AST_RDATA_HOLD_R: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd |=> $stable(r_rdata));  // R10

    for (genvar i = 0; i < N_SEM; i++) begin : g_prop
        logic lt, lg, rt, rg;
        assign lt = l_sel && l_wr && !l_wdata && (l_idx == IDX_W'(i));
        assign lg = l_sel && l_wr &&  l_wdata && (l_idx == IDX_W'(i));
        assign rt = r_sel && r_wr && !r_wdata && (r_idx == IDX_W'(i));
        assign rg = r_sel && r_wr &&  r_wdata && (r_idx == IDX_W'(i));

        AST_EXCLUSIVE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            !(held_l[i] && held_r[i]));  // R2
        AST_WAIT_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_l[i] |-> held_r[i]) and (wait_r[i] |-> held_l[i]));  // R6
        AST_FREE_GRANT_L: assert property (@(posedge clk) disable iff (!rst_n)
            (!held_l[i] && !held_r[i] && lt) |=> held_l[i]);  // R3
        AST_OWNER_KEPT_L: assert property (@(posedge clk) disable iff (!rst_n)
            (held_l[i] && !lg) |=> held_l[i]);  // R6
        AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (held_l[i] && lg && !wait_r[i] && !rt) |=> (!held_l[i] && !held_r[i]));  // R5
        AST_HANDOFF_R: assert property (@(posedge clk) disable iff (!rst_n)
            (held_l[i] && lg && wait_r[i]) |=> (held_r[i] && !wait_r[i]));  // R7
        AST_HANDOFF_L: assert property (@(posedge clk) disable iff (!rst_n)
            (held_r[i] && rg && wait_l[i]) |=> (held_l[i] && !wait_l[i]));  // R7
        AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (!held_l[i] && !held_r[i] && lt && rt) |=> (held_l[i] && wait_r[i]));  // R8
        AST_FOREIGN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (held_r[i] && lg && !rg) |=> (held_r[i] && (wait_l[i] == $past(wait_l[i]))));  // R9
    end

endmodule

bind sem_bank sem_bank_chk #(.N_SEM(N_SEM)) u_sem_bank_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_sel   (l_sel),
    .l_wr    (l_wr),
    .l_idx   (l_idx),
    .l_wdata (l_wdata),
    .l_rdata (l_rdata),
    .r_sel   (r_sel),
    .r_wr    (r_wr),
    .r_idx   (r_idx),
    .r_wdata (r_wdata),
    .r_rdata (r_rdata),
    .held_l  (held_l_w),
    .held_r  (held_r_w),
    .wait_l  (wait_l_w),
    .wait_r  (wait_r_w)
);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sel = 1'b0, l_wr = 1'b0, l_wdata = 1'b0;
    logic [2:0] l_idx = '0;
    logic       r_sel = 1'b0, r_wr = 1'b0, r_wdata = 1'b0;
    logic [2:0] r_idx = '0;
    logic       l_rdata, r_rdata;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // reference model: 0 free, 1 left, 2 right
    int  own [8];
    bit  qwl [8];
    bit  qwr [8];
    int  exp_l = 1;
    int  exp_r = 1;

    always #(CLK_P/2) clk = ~clk;

    sem_bank u_sem_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_sel   (l_sel),
        .l_wr    (l_wr),
        .l_idx   (l_idx),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_sel   (r_sel),
        .r_wr    (r_wr),
        .r_idx   (r_idx),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // drive one cycle at a falling edge, advance the model, compare at the next falling edge
    task automatic step(input bit ls, input bit lw, input bit ld, input int li,
                        input bit rs, input bit rw, input bit rd, input int ri,
                        input string tag);
        bit rel_l, rel_r, req_l, req_r;
        l_sel = ls; l_wr = lw; l_wdata = ld; l_idx = 3'(li);
        r_sel = rs; r_wr = rw; r_wdata = rd; r_idx = 3'(ri);
        if (ls && !lw) exp_l = (own[li] == 1) ? 0 : 1;
        if (rs && !rw) exp_r = (own[ri] == 2) ? 0 : 1;
        rel_l = ls && lw && ld && (own[li] == 1);
        rel_r = rs && rw && rd && (own[ri] == 2);
        req_l = ls && lw && !ld;
        req_r = rs && rw && !rd;
        if (rel_l) begin
            if (qwr[li]) begin own[li] = 2; qwr[li] = 0; end else own[li] = 0;
        end
        if (rel_r) begin
            if (qwl[ri]) begin own[ri] = 1; qwl[ri] = 0; end else own[ri] = 0;
        end
        if (req_l) begin
            if (own[li] == 0) own[li] = 1; else if (own[li] == 2) qwl[li] = 1;
        end
        if (req_r) begin
            if (own[ri] == 0) own[ri] = 2; else if (own[ri] == 1) qwr[ri] = 1;
        end
        @(negedge clk);
        check(tag, "l_rdata", int'(l_rdata), exp_l);
        check(tag, "r_rdata", int'(r_rdata), exp_r);
        if (ls && !lw && rs && !rw && li == ri) begin
            check("R2", "both ports own same index", int'(!l_rdata && !r_rdata), 0);
        end
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic rd_both(input int i, input string tag);
        step(1, 0, 0, i, 1, 0, 0, i, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 8; k++) begin own[k] = 0; qwl[k] = 0; qwr[k] = 0; end
        repeat (3) @(negedge clk);
        check("R1", "l_rdata in reset", int'(l_rdata), 1);
        check("R1", "r_rdata in reset", int'(r_rdata), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every index free on both ports
        for (int k = 0; k < 8; k++) rd_both(k, "R1");

        // R3 / R4: left takes 3
        step(1, 1, 0, 3, 0, 0, 0, 0, "R3");
        rd_both(3, "R4");
        check("R4", "left owns 3", int'(l_rdata), 0);
        check("R4", "right sees 3 taken", int'(r_rdata), 1);

        // R11: left asks again for 3, still owner
        step(1, 1, 0, 3, 0, 0, 0, 0, "R11");
        rd_both(3, "R11");

        // R6: right queues for 3, left keeps it
        step(0, 0, 0, 0, 1, 1, 0, 3, "R6");
        step(0, 0, 0, 0, 1, 1, 0, 3, "R11");
        rd_both(3, "R6");
        check("R6", "left still owns 3", int'(l_rdata), 0);

        // R9: right releases 3 it does not own; queue must survive
        step(0, 0, 0, 0, 1, 1, 1, 3, "R9");
        rd_both(3, "R9");

        // R7: left releases 3, right gets it at once
        step(1, 1, 1, 3, 0, 0, 0, 0, "R7");
        rd_both(3, "R7");
        check("R7", "right owns 3 after handoff", int'(r_rdata), 0);
        check("R7", "left lost 3", int'(l_rdata), 1);

        // R5: right releases 3, it becomes free
        step(0, 0, 0, 0, 1, 1, 1, 3, "R5");
        rd_both(3, "R5");

        // R8: tie on free 5
        step(1, 1, 0, 5, 1, 1, 0, 5, "R8");
        rd_both(5, "R8");
        check("R8", "left wins tie", int'(l_rdata), 0);
        step(1, 1, 1, 5, 0, 0, 0, 0, "R8");
        rd_both(5, "R8");
        check("R8", "right queued then granted", int'(r_rdata), 0);
        step(0, 0, 0, 0, 1, 1, 1, 5, "R5");

        // R10: writes with select low do nothing, rdata holds without a read
        step(0, 1, 0, 1, 0, 1, 0, 2, "R10");
        idle("R10");
        rd_both(1, "R10");
        rd_both(2, "R10");
        step(1, 1, 0, 6, 0, 0, 0, 0, "R3");
        idle("R10");
        check("R10", "l_rdata held without read", int'(l_rdata), 1);
        step(1, 1, 1, 6, 0, 0, 0, 0, "R5");

        // mixed traffic compared cycle by cycle
        for (int n = 0; n < 3000; n++) begin
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3)), "R4");
        end
        for (int k = 0; k < 8; k++) rd_both(k, "R2");

        finish_run();
    end

endmodule